// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block gathers interrupt requests from one dedicated interrupt pin and twelve general-purpose pins. The dedicated pin can be set to raise a request on a low level, on either edge, on a falling edge or on a rising edge. The general pins form two pin-change groups: group 0 holds pins 7..0 and group 1 holds pins 11..8. Each group has its own pin mask, enable and sticky flag. The flag sets when any unmasked pin in the group toggles. Pins are sampled directly, so detection still works while the same device drives them as outputs. Firmware can use this to force an interrupt by writing a port bit.

A small register port sets the sense mode, the enables and the masks, and clears flags by writing ones. Edge detection on the dedicated pin needs the I/O clock enable. Low-level sensing does not, and neither does pin-change sensing. Both feed a combinational wake output taken straight from the raw pins, so a sleeping system can be woken without any clock.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every register reads 0x00, all three requests are low and wake is low.
- R2: Register map (2-bit address, 8-bit data):
  - Address 0 is control: bits [1:0] sense, bit 2 dedicated-pin enable, bit 3 group 0 enable, bit 4 group 1 enable.
  - Address 1 is the 8-bit group 0 mask.
  - Address 2 is the 4-bit group 1 mask.
  - Address 3 holds the flags: bit 0 dedicated pin, bit 1 group 0, bit 2 group 1.
  - Unused bits read zero.
- R3: With sense 2'b10, a falling edge on the dedicated pin sets flag bit 0 three clock edges after the pin changes. A rising edge does not set it.
- R4: With sense 2'b11, a rising edge sets flag bit 0 three edges later. A falling edge does not set it.
- R5: With sense 2'b01, either edge sets flag bit 0 three edges later.
- R6: With sense 2'b00, no flag is latched. The dedicated request equals its enable ANDed with the inverted pin, two edges late, and stays high for as long as the pin is low.
- R7: While the I/O clock enable is low, edges on the dedicated pin do not set its flag.
- R8: A toggle on a group 0 pin whose mask bit is 1 sets flag bit 1 three edges later. A toggle on a masked-off pin has no effect.
- R9: Group 1 uses its own 4-bit mask (mask bit n covers pin 8+n) and its own flag bit 2. Group 0 is not touched by it.
- R10: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R11: Each request is its flag ANDed with its enable. A flag still sets while its enable is 0.
- R12: Wake is combinational from the raw pins, independent of the I/O clock enable. It is high while the dedicated pin is enabled, in low-level sense, and low. It is also high while an enabled group has an unmasked raw pin that differs from its last sampled value.
- R13: A write to a mask, or a control write that changes the sense field, blocks detection for the cycle after the write. A toggle already in flight is therefore not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ioclk_en_i | input | 1 | I/O clock enable, gates edge sensing |
| ext_pin_i | input | 1 | Dedicated interrupt pin |
| pins_i | input | 12 | General pins, 7..0 group 0, 11..8 group 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_ext_o | output | 1 | Dedicated-pin request |
| irq_pc0_o | output | 1 | Group 0 request |
| irq_pc1_o | output | 1 | Group 1 request |
| wake_o | output | 1 | Asynchronous wake |

## Verification
The timing for each result is fixed relative to the stimulus:

| Result | When it is due |
|---|---|
| Flag from a pin change | Third rising edge after the change (two synchronizer flops plus the flag flop) |
| Low-level request | Second rising edge after the change |
| Register writes | Next edge |
| Wake | Combinationally, with no edge |

The bench drives inputs on the falling clock edge and waits exactly that many rising edges. It then samples on the following falling edge, or 1 ns after the drive for wake. Each result is therefore checked in the first cycle it is due. The same-cycle clear and the mask-write guard are placed on the precise edge where the set pulse and the write meet.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_MASK0 = 2'd1;
  localparam logic [1:0] ADDR_MASK1 = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_pin_sense.sv
module ext_irq_pin_sense
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_sync_i,
  input  logic   ioclk_en_i,
  input  sense_e sense_i,
  input  logic   reload_i,
  input  logic   en_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   irq_o
);
  logic prev_q, flag_q, hit, rise, fall, set;

  assign rise = pin_sync_i & ~prev_q;
  assign fall = ~pin_sync_i & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  // edge sensing needs the I/O clock
  assign set = hit & ioclk_en_i & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_sync_i;
      flag_q <= set | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = en_i & ((sense_i == SENSE_LOW) ? ~pin_sync_i : flag_q);

  // R7
  ext_ioclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioclk_en_i && !clr_i) |=> $stable(flag_q));

  // R6
  ext_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_LOW) |=> !$rose(flag_q));
endmodule

// File: rtl/ext_irq_pc_group.sv
module ext_irq_pc_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_sync_i,
  input  logic [W-1:0] mask_i,
  input  logic         reload_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic [W-1:0] prev_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q;
  logic         flag_q, set;

  assign set = (|((pins_sync_i ^ prev_q) & mask_i)) & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pins_sync_i;
      flag_q <= set | (flag_q & ~clr_i);
    end
  end

  assign prev_o = prev_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  // R8
  pc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|((pins_sync_i ^ prev_q) & mask_i)) && !reload_i) |=> flag_q);

  // R10
  pc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (reload_i || (((pins_sync_i ^ prev_q) & mask_i) == '0))) |=> !flag_q);

  // R11
  pc_irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int G0_W        = 8,
  parameter int G1_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ioclk_en_i,
  input  logic                 ext_pin_i,
  input  logic [G0_W+G1_W-1:0] pins_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_ext_o,
  output logic                 irq_pc0_o,
  output logic                 irq_pc1_o,
  output logic                 wake_o
);
  localparam int NP = G0_W + G1_W;
  localparam int SW = NP + 1;

  logic [SW-1:0]   sync_q;
  sense_e          sense_q;
  logic [2:0]      en_q;
  logic [G0_W-1:0] mask0_q, prev0;
  logic [G1_W-1:0] mask1_q, prev1;
  logic            rl_ext_q, rl0_q, rl1_q;
  logic            wr_ctrl, wr_mask0, wr_mask1, wr_flags;
  logic [2:0]      clr, flags;

  ext_irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({ext_pin_i, pins_i}), .q_o(sync_q)
  );

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_mask0 = reg_we_i && (reg_addr_i == ADDR_MASK0);
  assign wr_mask1 = reg_we_i && (reg_addr_i == ADDR_MASK1);
  assign wr_flags = reg_we_i && (reg_addr_i == ADDR_FLAGS);
  assign clr      = wr_flags ? reg_wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q  <= SENSE_LOW;
      en_q     <= '0;
      mask0_q  <= '0;
      mask1_q  <= '0;
      rl_ext_q <= 1'b0;
      rl0_q    <= 1'b0;
      rl1_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sense_q <= sense_e'(reg_wdata_i[1:0]);
        en_q    <= reg_wdata_i[4:2];
      end
      if (wr_mask0) mask0_q <= reg_wdata_i[G0_W-1:0];
      if (wr_mask1) mask1_q <= reg_wdata_i[G1_W-1:0];
      // block detection for one cycle after a reconfiguration
      rl_ext_q <= wr_ctrl && (reg_wdata_i[1:0] != sense_q);
      rl0_q    <= wr_mask0;
      rl1_q    <= wr_mask1;
    end
  end

  ext_irq_pin_sense u_ext (
    .clk_i, .rst_ni,
    .pin_sync_i (sync_q[NP]),
    .ioclk_en_i,
    .sense_i    (sense_q),
    .reload_i   (rl_ext_q),
    .en_i       (en_q[0]),
    .clr_i      (clr[0]),
    .flag_o     (flags[0]),
    .irq_o      (irq_ext_o)
  );

  ext_irq_pc_group #(.W(G0_W)) u_pc0 (
    .clk_i, .rst_ni,
    .pins_sync_i (sync_q[G0_W-1:0]),
    .mask_i      (mask0_q),
    .reload_i    (rl0_q),
    .en_i        (en_q[1]),
    .clr_i       (clr[1]),
    .prev_o      (prev0),
    .flag_o      (flags[1]),
    .irq_o       (irq_pc0_o)
  );

  ext_irq_pc_group #(.W(G1_W)) u_pc1 (
    .clk_i, .rst_ni,
    .pins_sync_i (sync_q[NP-1:G0_W]),
    .mask_i      (mask1_q),
    .reload_i    (rl1_q),
    .en_i        (en_q[2]),
    .clr_i       (clr[2]),
    .prev_o      (prev1),
    .flag_o      (flags[2]),
    .irq_o       (irq_pc1_o)
  );

  // raw-pin wake path, no clock needed
  assign wake_o = (en_q[0] & (sense_q == SENSE_LOW) & ~ext_pin_i)
                | (en_q[1] & (|((pins_i[G0_W-1:0] ^ prev0) & mask0_q)))
                | (en_q[2] & (|((pins_i[NP-1:G0_W] ^ prev1) & mask1_q)));

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o[4:0]      = {en_q, sense_q};
      ADDR_MASK0: reg_rdata_o[G0_W-1:0] = mask0_q;
      ADDR_MASK1: reg_rdata_o[G1_W-1:0] = mask1_q;
      default:    reg_rdata_o[2:0]      = flags;
    endcase
  end

  // R12
  wake_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[0] && sense_q == SENSE_LOW && !ext_pin_i) |-> wake_o);
endmodule

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
  logic        clk = 1'b0, rst_n = 1'b0, ioclk_en = 1'b1, ext_pin = 1'b1;
  logic [11:0] pins = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        irq_ext, irq_pc0, irq_pc1, wake;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ext_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .ioclk_en_i(ioclk_en), .ext_pin_i(ext_pin),
    .pins_i(pins), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_ext_o(irq_ext), .irq_pc0_o(irq_pc0),
    .irq_pc1_o(irq_pc1), .wake_o(wake)
  );

  // {sense[1:0], pin before, pin after, ioclk_en, expected flag}
  localparam logic [5:0] VEC [9] = '{
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    string tag;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r); chk("R1", r, 8'h00);
    end
    chk("R1", {5'b0, irq_ext, irq_pc0, irq_pc1}, 8'h00);
    chk("R1", {7'b0, wake}, 8'h00);

    // R2 register map
    wr(2'd1, 8'hA5); rd(2'd1, r); chk("R2", r, 8'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, r); chk("R2", r, 8'h0F);
    wr(2'd0, 8'hFF); rd(2'd0, r); chk("R2", r, 8'h1F);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    cyc(3); wr(2'd3, 8'h07);

    // dedicated-pin vectors: R3 R4 R5 R6 R7
    for (int i = 0; i < 9; i++) begin
      logic [5:0] v;
      v = VEC[i];
      ioclk_en = v[1];
      wr(2'd0, {3'b000, 3'b001, v[5:4]});
      ext_pin = v[3];
      cyc(5);
      wr(2'd3, 8'h01);
      ext_pin = v[2];
      cyc(3);
      if (!v[1]) tag = "R7";
      else case (v[5:4])
        2'b00:   tag = "R6";
        2'b01:   tag = "R5";
        2'b10:   tag = "R3";
        default: tag = "R4";
      endcase
      rd(2'd3, r);
      chk(tag, {7'b0, r[0]}, {7'b0, v[0]});
      chk(tag, {7'b0, irq_ext}, {7'b0, (v[5:4] == 2'b00) ? ~v[2] : v[0]});
    end
    ioclk_en = 1'b1; ext_pin = 1'b1;
    cyc(4); wr(2'd3, 8'h07);

    // R8 group 0 masked and unmasked toggles
    wr(2'd0, 8'h0B); wr(2'd1, 8'h04); cyc(2);
    pins[3] = 1'b1; cyc(3);
    rd(2'd3, r); chk("R8", r, 8'h00);
    pins[2] = 1'b1; cyc(3);
    rd(2'd3, r); chk("R8", r, 8'h02);
    chk("R8", {7'b0, irq_pc0}, 8'h01);

    // R10 clear semantics
    wr(2'd3, 8'h00); rd(2'd3, r); chk("R10", r, 8'h02);
    wr(2'd3, 8'h02); rd(2'd3, r); chk("R10", r, 8'h00);
    pins[2] = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    wr(2'd3, 8'h02);  // clear meets the set edge
    rd(2'd3, r); chk("R10", r, 8'h02);
    wr(2'd3, 8'h02);

    // R13 mask write blocks an in-flight toggle
    wr(2'd1, 8'h00); cyc(2);
    pins[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    wr(2'd1, 8'h04);
    cyc(1);
    rd(2'd3, r); chk("R13", r, 8'h00);

    // R9 R11 group 1 with its enable off
    wr(2'd2, 8'h02); cyc(2);
    pins[9] = 1'b1; cyc(3);
    rd(2'd3, r); chk("R9", r, 8'h04);
    chk("R11", {7'b0, irq_pc1}, 8'h00);
    wr(2'd0, 8'h13);
    chk("R11", {7'b0, irq_pc1}, 8'h01);
    pins[8] = 1'b1; cyc(3);
    rd(2'd3, r); chk("R9", r, 8'h04);
    wr(2'd3, 8'h07);

    // R12 wake with I/O clock stopped
    ioclk_en = 1'b0;
    wr(2'd0, 8'h1C); cyc(3);
    chk("R12", {7'b0, wake}, 8'h00);
    ext_pin = 1'b0; #1;
    chk("R12", {7'b0, wake}, 8'h01);
    ext_pin = 1'b1; cyc(3);
    chk("R12", {7'b0, wake}, 8'h00);
    pins[2] = 1'b0; #1;
    chk("R12", {7'b0, wake}, 8'h01);
    cyc(3);
    chk("R12", {7'b0, wake}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule